// File: doc/BRIEF.md
# Bus Access Violation Capture Unit

This unit sits beside a bus protection checker and keeps a record of every illegal access that the checker reports. Each protected slave index owns one status bit and one mask bit. The status bits are packed thirty-two to a word, and the interrupt line is high while any status bit whose mask bit is clear is set. The unit does not judge whether an access is legal. It only records what the checker reports.

Slave indices are gathered into groups of equal span. The first violation that lands in an idle group stores its full details in that group's private record and raises the group's pending flag. Software never reads the records directly. It picks a group with a one-hot select word and starts a copy. After a fixed latency the copy control register reports done, and the two debug registers then hold that group's record. Software then clears the group's pending flag by writing one to its bit, so the next violation in that group can be captured.

The unit also has a global control register that enables or stops capture. While capture is stopped, violation events leave no trace.

Top module: `bus_viol_capture`

## Requirements
- R1: After reset, every valid mask bit reads 1, and all status bits, pending flags, the select word, copy control, debug registers and global control read 0. The interrupt output is low.
- R2: Slave index i maps to bit i%32 of word i/32. Mask words start at byte offset 0x000 and status words start at 0x400, four bytes apart. With 511 indices, bit 31 of word 15 is not implemented: it reads 0 and ignores writes.
- R3: A captured event sets its index's status bit. Writing a word with ones to the status bank clears exactly those bits (write-one-to-clear). A new event wins over a clear of the same bit in the same cycle.
- R4: The irq output is 1 exactly while some status bit is set whose mask bit is 0. A mask bit of 1 keeps its index from raising irq.
- R5: At offset 0xF00, writing a word with bit 31 set enables capture and writing one with bit 2 set stops it. If both bits are set, stop wins. The register reads back the enable state in bit 31. Events that arrive while capture is stopped change no status bit and no pending flag.
- R6: An index belongs to group idx/64 (indices 0..63 to group 0, and so on up to group 7). Group pending register 0xF10 has one bit per group, set when that group captures a record. Writing ones there clears the named flags.
- R7: While a group's pending flag is set, later events in that group set their status bits but leave the stored record unchanged. After the flag is cleared, the next event is captured again.
- R8: Select register 0xF14 holds a one-hot group word. Writing 1 to copy control 0xF20 makes it read 1 for 4 cycles and then read 3, and at that point the debug registers hold the selected record. Writing 0 returns copy control to 0.
- R9: Debug0 (0x904-4 = 0x900) reads {4'b0, addr[35:32], read, write, domain[5:0], master[15:0]}, with read equal to the inverse of the event's write flag. Debug1 (0x904) reads addr[31:0].
- R10: A copy started with a select word that is zero or has more than one bit set still completes (reads 3 after 4 cycles) but leaves both debug registers unchanged.
- R11: An event whose index is 511 or above is ignored entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| ev_valid | input | 1 | Violation event strobe |
| ev_idx | input | 9 | Slave index of the violation |
| ev_master | input | 16 | Master ID of the offending access |
| ev_domain | input | 6 | Domain ID of the offending access |
| ev_write | input | 1 | 1 for a write access, 0 for a read |
| ev_addr | input | 36 | Address of the offending access |
| irq | output | 1 | Level interrupt, unmasked status pending |

## Verification
A table of events spread over groups 0, 1, 3, 4 and 7 drives the main path. The events mix read and write flags, master and domain values, and upper and lower address bits. For each one the bench checks the status bit, the pending bit, irq under mask and unmask, the copied debug words and the write-one-to-clear behaviour. This separates errors in word and bit placement, group decoding, and debug field packing. Directed runs then send a second event into a group that already holds a record, to tell "record kept" from "record overwritten". They also run copies with empty and multi-bit select words, send events while capture is stopped and at index 511, and write both control bits at once to show that stop has priority.

// File: rtl/bus_viol_capture.sv
module bus_viol_capture #(
  parameter int NUM_IDX    = 511,
  parameter int NUM_GROUPS = 8,
  parameter int COPY_CYC   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        ev_valid,
  input  logic [8:0]  ev_idx,
  input  logic [15:0] ev_master,
  input  logic [5:0]  ev_domain,
  input  logic        ev_write,
  input  logic [35:0] ev_addr,
  output logic        irq
);
  localparam int NUM_WORDS = (NUM_IDX + 31) / 32;
  localparam int LAST_BITS = NUM_IDX - 32 * (NUM_WORDS - 1);
  localparam int GRP_SPAN  = (NUM_IDX + NUM_GROUPS - 1) / NUM_GROUPS;
  localparam int GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
  localparam int CNT_W     = $clog2(COPY_CYC + 1);
  localparam logic [11:0] A_MASK = 12'h000;
  localparam logic [11:0] A_STAT = 12'h400;
  localparam logic [11:0] A_DBG0 = 12'h900;
  localparam logic [11:0] A_DBG1 = 12'h904;
  localparam logic [11:0] A_CTRL = 12'hF00;
  localparam logic [11:0] A_PEND = 12'hF10;
  localparam logic [11:0] A_SEL  = 12'hF14;
  localparam logic [11:0] A_COPY = 12'hF20;
  localparam logic [1:0] CP_IDLE = 2'd0, CP_BUSY = 2'd1, CP_DONE = 2'd3;

  function automatic logic [31:0] wvalid(input int w);
    if (w < NUM_WORDS - 1) return 32'hFFFF_FFFF;
    return 32'hFFFF_FFFF >> (32 - LAST_BITS);
  endfunction

  logic [31:0] mask_w [NUM_WORDS];
  logic [31:0] stat_w [NUM_WORDS];
  logic [31:0] mask_nxt [NUM_WORDS];
  logic [31:0] stat_nxt [NUM_WORDS];
  logic [NUM_GROUPS-1:0] pend_q, sel_q, pend_clr, cap;
  logic [15:0] rec_mst [NUM_GROUPS];
  logic [5:0]  rec_dom [NUM_GROUPS];
  logic        rec_wr  [NUM_GROUPS];
  logic [35:0] rec_adr [NUM_GROUPS];
  logic        en_q;
  logic [1:0]  copy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [31:0] dbg0_q, dbg1_q;

  wire [7:0] widx     = reg_addr[9:2];
  wire       in_mask  = (reg_addr[11:10] == A_MASK[11:10]) && (int'(widx) < NUM_WORDS);
  wire       in_stat  = (reg_addr[11:10] == A_STAT[11:10]) && (int'(widx) < NUM_WORDS);
  wire       ev_ok    = en_q && ev_valid && (int'(ev_idx) < NUM_IDX);
  wire [GRP_W-1:0] ev_grp = GRP_W'(int'(ev_idx) / GRP_SPAN);
  wire       copy_wr  = reg_we && reg_addr == A_COPY;
  wire       copy_fin = copy_q == CP_BUSY && cnt_q == CNT_W'(COPY_CYC - 1);

  assign pend_clr = (reg_we && reg_addr == A_PEND) ? reg_wdata[NUM_GROUPS-1:0] : '0;

  always_comb begin
    for (int w = 0; w < NUM_WORDS; w++) begin
      mask_nxt[w] = mask_w[w];
      stat_nxt[w] = stat_w[w];
      if (reg_we && in_mask && int'(widx) == w) mask_nxt[w] = reg_wdata & wvalid(w);
      if (reg_we && in_stat && int'(widx) == w) stat_nxt[w] = stat_w[w] & ~reg_wdata;
      if (ev_ok && int'(ev_idx[8:5]) == w) stat_nxt[w][ev_idx[4:0]] = 1'b1;
    end
  end

  always_comb begin
    irq = 1'b0;
    for (int w = 0; w < NUM_WORDS; w++) irq = irq | (|(stat_w[w] & ~mask_w[w]));
  end

  always_comb begin
    for (int g = 0; g < NUM_GROUPS; g++)
      cap[g] = ev_ok && ev_grp == GRP_W'(g) && !(pend_q[g] && !pend_clr[g]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        mask_w[w] <= wvalid(w);
        stat_w[w] <= '0;
      end
    end else begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        mask_w[w] <= mask_nxt[w];
        stat_w[w] <= stat_nxt[w];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      for (int g = 0; g < NUM_GROUPS; g++) begin
        rec_mst[g] <= '0;
        rec_dom[g] <= '0;
        rec_wr[g]  <= 1'b0;
        rec_adr[g] <= '0;
      end
    end else begin
      pend_q <= (pend_q & ~pend_clr) | cap;
      for (int g = 0; g < NUM_GROUPS; g++) begin
        if (cap[g]) begin
          rec_mst[g] <= ev_master;
          rec_dom[g] <= ev_domain;
          rec_wr[g]  <= ev_write;
          rec_adr[g] <= ev_addr;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= '0;
    end else begin
      if (reg_we && reg_addr == A_CTRL) begin
        if (reg_wdata[2]) en_q <= 1'b0;
        else if (reg_wdata[31]) en_q <= 1'b1;
      end
      if (reg_we && reg_addr == A_SEL) sel_q <= reg_wdata[NUM_GROUPS-1:0];
    end
  end

  logic [GRP_W-1:0] sel_idx;
  always_comb begin
    sel_idx = '0;
    for (int g = 0; g < NUM_GROUPS; g++) if (sel_q[g]) sel_idx = GRP_W'(g);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      copy_q <= CP_IDLE;
      cnt_q  <= '0;
      dbg0_q <= '0;
      dbg1_q <= '0;
    end else if (copy_wr) begin
      copy_q <= reg_wdata[0] ? CP_BUSY : CP_IDLE;
      cnt_q  <= '0;
    end else if (copy_q == CP_BUSY) begin
      if (copy_fin) begin
        copy_q <= CP_DONE;
        if ($onehot(sel_q)) begin
          dbg0_q <= {4'h0, rec_adr[sel_idx][35:32], !rec_wr[sel_idx], rec_wr[sel_idx],
                     rec_dom[sel_idx], rec_mst[sel_idx]};
          dbg1_q <= rec_adr[sel_idx][31:0];
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (in_mask) reg_rdata = mask_w[widx[$clog2(NUM_WORDS)-1:0]];
    else if (in_stat) reg_rdata = stat_w[widx[$clog2(NUM_WORDS)-1:0]];
    else begin
      case (reg_addr)
        A_DBG0: reg_rdata = dbg0_q;
        A_DBG1: reg_rdata = dbg1_q;
        A_CTRL: reg_rdata = {en_q, 31'b0};
        A_PEND: reg_rdata = 32'(pend_q);
        A_SEL:  reg_rdata = 32'(sel_q);
        A_COPY: reg_rdata = 32'(copy_q);
        default: reg_rdata = '0;
      endcase
    end
  end

  logic [CNT_W:0] a_busy_cyc;
  always_ff @(posedge clk) begin
    if (!rst_n || copy_wr) a_busy_cyc <= '0;
    else if (copy_q == CP_BUSY) a_busy_cyc <= a_busy_cyc + 1'b1;
  end

  a_r8_copy_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_q == CP_DONE && $past(copy_q) == CP_BUSY) |-> a_busy_cyc == (CNT_W+1)'(COPY_CYC));

  a_r8_debug_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !copy_fin |=> ($stable(dbg0_q) && $stable(dbg1_q)));

  a_r10_bad_select: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_fin && !$onehot(sel_q)) |=> ($stable(dbg0_q) && $stable(dbg1_q)));

  a_r5_stopped_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (pend_q & ~$past(pend_q)) == '0);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_rec_chk
    a_r7_record_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[g] && !pend_clr[g]) |=> ($stable(rec_mst[g]) && $stable(rec_adr[g])
                                        && $stable(rec_dom[g]) && $stable(rec_wr[g])));
  end
endmodule

// File: tb/bus_viol_capture_test.sv
module bus_viol_capture_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_DBG0 = 12'h900, A_DBG1 = 12'h904, A_CTRL = 12'hF00,
                          A_PEND = 12'hF10, A_SEL = 12'hF14, A_COPY = 12'hF20;
  // vector fields: idx(9) master(16) domain(6) write(1) addr(36)
  localparam logic [67:0] VEC [5] = '{
    {9'd5,   16'hA5A5, 6'd3,  1'b1, 36'hF_1234_5678},
    {9'd70,  16'h0001, 6'd63, 1'b0, 36'h0_DEAD_BEEF},
    {9'd200, 16'hFFFF, 6'd0,  1'b1, 36'h8_0000_0001},
    {9'd300, 16'h1234, 6'd21, 1'b0, 36'h3_CAFE_F00D},
    {9'd510, 16'h8000, 6'd42, 1'b1, 36'h5_5555_AAAA}
  };

  logic clk = 0, rst_n = 0, reg_we = 0, ev_valid = 0, ev_write = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [8:0] ev_idx = '0;
  logic [15:0] ev_master = '0;
  logic [5:0] ev_domain = '0;
  logic [35:0] ev_addr = '0;
  logic irq;
  int checks = 0, fails = 0;
  logic [31:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_viol_capture uut (.clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .ev_valid, .ev_idx, .ev_master, .ev_domain, .ev_write, .ev_addr, .irq);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic send(input logic [67:0] e);
    @(negedge clk);
    ev_valid = 1; {ev_idx, ev_master, ev_domain, ev_write, ev_addr} = e;
    @(negedge clk); ev_valid = 0;
  endtask

  function automatic logic [31:0] exp_d0(input logic [67:0] e);
    return {4'h0, e[35:32], !e[36], e[36], e[42:37], e[58:43]};
  endfunction

  task automatic copy(input logic [31:0] sel, input string tag);
    wr(A_SEL, sel);
    wr(A_COPY, 32'd1);
    rd(A_COPY, v); chk({tag, " copy busy"}, v, 32'd1);
    repeat (3) @(negedge clk);
    rd(A_COPY, v); chk({tag, " copy still busy"}, v, 32'd1);
    @(negedge clk);
    rd(A_COPY, v); chk({tag, " copy done"}, v, 32'd3);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(12'h000, v); chk("R1 mask word0", v, 32'hFFFF_FFFF);
    rd(12'h03C, v); chk("R1 R2 mask word15", v, 32'h7FFF_FFFF);
    rd(12'h400, v); chk("R1 status word0", v, 0);
    rd(A_PEND, v);  chk("R1 pending", v, 0);
    rd(A_COPY, v);  chk("R1 copy ctrl", v, 0);
    rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
    rd(A_DBG0, v);  chk("R1 dbg0", v, 0);
    chk("R1 irq", 32'(irq), 0);

    // R5 stopped: event ignored
    send({9'd10, 16'h1, 6'd1, 1'b1, 36'h1});
    rd(12'h400, v); chk("R5 stopped status", v, 0);
    rd(A_PEND, v);  chk("R5 stopped pending", v, 0);
    wr(A_CTRL, 32'h8000_0004);
    rd(A_CTRL, v);  chk("R5 stop wins", v, 0);
    wr(A_CTRL, 32'h8000_0000);
    rd(A_CTRL, v);  chk("R5 enable", v, 32'h8000_0000);

    // R2 unimplemented bit
    wr(12'h03C, 32'hFFFF_FFFF);
    rd(12'h03C, v); chk("R2 bit 511 masked off", v, 32'h7FFF_FFFF);

    // table walk: R2 R3 R4 R6 R8 R9
    for (int i = 0; i < 5; i++) begin
      automatic logic [67:0] e = VEC[i];
      automatic int idx = int'(e[67:59]);
      automatic logic [11:0] sw = 12'h400 + 12'(4 * (idx / 32));
      automatic logic [11:0] mw = 12'(4 * (idx / 32));
      send(e);
      rd(sw, v);     chk("R2 R3 status bit", v, 32'h1 << (idx % 32));
      rd(A_PEND, v); chk("R6 pending group", v, 32'h1 << (idx / 64));
      chk("R4 irq masked", 32'(irq), 0);
      wr(mw, ~(32'h1 << (idx % 32)));
      chk("R4 irq unmasked", 32'(irq), 1);
      wr(mw, 32'hFFFF_FFFF);
      chk("R4 irq remasked", 32'(irq), 0);
      copy(32'h1 << (idx / 64), "R8");
      rd(A_DBG0, v); chk("R9 dbg0", v, exp_d0(e));
      rd(A_DBG1, v); chk("R9 dbg1", v, e[31:0]);
      wr(A_COPY, 0);
      rd(A_COPY, v); chk("R8 copy idle", v, 0);
      wr(sw, 32'h1 << (idx % 32));
      rd(sw, v);     chk("R3 w1c", v, 0);
      wr(A_PEND, 32'hFF);
      rd(A_PEND, v); chk("R6 pending cleared", v, 0);
    end

    // R3 partial clear
    send({9'd1, 16'h0, 6'd0, 1'b0, 36'h0});
    send({9'd2, 16'h0, 6'd0, 1'b0, 36'h0});
    wr(12'h400, 32'h2);
    rd(12'h400, v); chk("R3 partial clear", v, 32'h4);
    wr(12'h400, 32'hFFFF_FFFF);
    wr(A_PEND, 32'hFF);

    // R7 record kept
    send({9'd64, 16'h0011, 6'd1, 1'b1, 36'h0_0000_1000});
    send({9'd65, 16'h0022, 6'd2, 1'b0, 36'h0_0000_2000});
    rd(12'h408, v); chk("R7 both status bits", v, 32'h3);
    copy(32'h2, "R7");
    rd(A_DBG0, v);  chk("R7 first record kept", v, {4'h0, 4'h0, 1'b0, 1'b1, 6'd1, 16'h0011});
    wr(A_PEND, 32'h2);
    send({9'd66, 16'h0033, 6'd3, 1'b0, 36'h0_0000_3000});
    copy(32'h2, "R7");
    rd(A_DBG0, v);  chk("R7 recapture after clear", v, {4'h0, 4'h0, 1'b1, 1'b0, 6'd3, 16'h0033});
    rd(A_DBG1, v);  chk("R7 recapture addr", v, 32'h3000);

    // R10 bad select
    copy(32'h0, "R10 empty");
    rd(A_DBG0, v);  chk("R10 empty select dbg0", v, {4'h0, 4'h0, 1'b1, 1'b0, 6'd3, 16'h0033});
    copy(32'h3, "R10 multi");
    rd(A_DBG1, v);  chk("R10 multi select dbg1", v, 32'h3000);
    wr(A_PEND, 32'hFF);

    // R11 out-of-range index
    send({9'd511, 16'h7, 6'd7, 1'b1, 36'h7});
    rd(12'h43C, v); chk("R11 status word15", v, 0);
    rd(A_PEND, v);  chk("R11 pending", v, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule